// File: doc/BRIEF.md
# Registered Logic Device Sweep Sequencer

This controller characterises an unknown registered logic device by exhaustive stimulus. The device has no way to load its state directly. Before every test the sequencer therefore drives all device inputs low and clocks the device repeatedly. It continues until the captured outputs have held a chosen start pattern for a set number of consecutive clocks. It then drives one test value, issues one device clock and captures the outputs. The result goes out as a single record on a write port.

Test values run upward from 1 to the all-ones value. A full settling phase precedes every value. An all-zero input can leave the device in more than one stable pattern, so an optional second sweep repeats the whole range against an alternate start pattern. Record addresses continue on from the first sweep.

The write port is valid/ready. A record stays presented, unchanged, until the sink accepts it, and the sequence does nothing further while the record waits. Start, done and the timeout flag are plain level or pulse pins. The start patterns and the dual-sweep selector are latched when a run starts.

Top module: `pld_sweep_seq`

## Requirements
- R1: Between two accepted records there is exactly one device clock with a non-zero `dev_in`, and before it at least SETTLE_N device clocks with `dev_in` all zero.
- R2: The settling phase ends once SETTLE_N consecutive captures equal the target pattern. A device that already sits at the target therefore sees exactly SETTLE_N zero-input clocks before its first test clock.
- R3: If SETTLE_MAX settling captures pass without the device settling, the run stops. `err_timeout` and `done` go high, no record is written, and exactly SETTLE_MAX device clocks have been issued in that run.
- R4: Test values are applied in ascending order, 1 through 2^IN_W-1, with one record per value.
- R5: Each record is written at an address that starts at 0 with each run and rises by one per record. `wr_data` is {target pattern (top OUT_W bits), applied value (middle IN_W bits), captured output (low OUT_W bits)}.
- R6: With `dual_sweep` high, a second sweep over the same values follows, using `start_pat_b` as its target. Its addresses continue after those of the first sweep.
- R7: `dev_clk` is a single-cycle pulse. `dev_in` holds its value for at least SETUP_CYC cycles before the pulse, during the pulse, and for HOLD_CYC cycles after it, before the capture.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged. No record is skipped or repeated.
- R9: `done` rises after the last record or a timeout. It stays high with no device clock and no write until `start` is asserted again. A new start clears `err_timeout`.
- R10: After reset, `done`, `err_timeout`, `dev_clk` and `wr_valid` are low and `dev_in` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle or done |
| dual_sweep | input | 1 | Run a second sweep against `start_pat_b` |
| start_pat_a | input | OUT_W | Target settled pattern for the first sweep |
| start_pat_b | input | OUT_W | Target settled pattern for the second sweep |
| done | output | 1 | Run finished; held until the next start |
| err_timeout | output | 1 | Device failed to settle within SETTLE_MAX clocks |
| dev_in | output | IN_W | Input pattern driven to the device |
| dev_clk | output | 1 | Device clock strobe, one cycle wide |
| dev_out | input | OUT_W | Device outputs being captured |
| wr_valid | output | 1 | Record presented on the write port |
| wr_ready | input | 1 | Sink accepts the record |
| wr_addr | output | IN_W+1 | Record address |
| wr_data | output | 2*OUT_W+IN_W | Record: target, applied value, captured output |

## Verification
The bench builds the sequencer with IN_W=3, OUT_W=4, SETTLE_N=3, SETTLE_MAX=12, SETUP_CYC=2 and HOLD_CYC=1. This keeps a full dual sweep to fourteen records, so the value wrap, the switch between sweeps and the end of the address range are all reached within a few hundred cycles. A small device model in the bench shifts a selectable bit into its state under zero input, which gives two stable patterns. Adding any value then gives a predictable result. Its settling path is short enough that a target it can never reach triggers the timeout after twelve clocks. The two-cycle setup window is checked tightly, so a sequencer that pulses one cycle early is caught.

// File: rtl/pld_seq_pkg.sv
package pld_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DRIVE,
    S_PULSE,
    S_HOLD,
    S_EVAL,
    S_WRITE,
    S_DONE
  } seq_state_t;
endpackage

// File: rtl/pld_phase_timer.sv
module pld_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  assign last = run && (cnt == len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || last) cnt <= '0;
    else                        cnt <= cnt + CNT_W'(1);
  end

  // R7: a setup or hold window never overruns its length
  a_r7_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < len));
endmodule

// File: rtl/pld_settle_det.sv
module pld_settle_det #(
  parameter int OUT_W      = 8,
  parameter int SETTLE_N   = 4,
  parameter int SETTLE_MAX = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cap_vld,
  input  logic [OUT_W-1:0] cap_val,
  input  logic [OUT_W-1:0] target,
  output logic             settled,
  output logic             timeout
);
  localparam int RUN_W = $clog2(SETTLE_N + 1);
  localparam int TOT_W = $clog2(SETTLE_MAX + 1);

  logic [RUN_W-1:0] run_cnt;
  logic [TOT_W-1:0] tot_cnt;

  assign settled = (run_cnt == RUN_W'(SETTLE_N));
  assign timeout = (tot_cnt == TOT_W'(SETTLE_MAX)) && !settled;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      run_cnt <= '0;
      tot_cnt <= '0;
    end else if (cap_vld) begin
      if (cap_val != target)  run_cnt <= '0;
      else if (!settled)      run_cnt <= run_cnt + RUN_W'(1);
      if (tot_cnt != TOT_W'(SETTLE_MAX)) tot_cnt <= tot_cnt + TOT_W'(1);
    end
  end

  // R2: a capture off the target breaks any run of matches
  a_r2_run_breaks: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && !clr && cap_val != target) |=> !settled);
endmodule

// File: rtl/pld_sweep_seq.sv
module pld_sweep_seq
  import pld_seq_pkg::*;
#(
  parameter int IN_W       = 8,
  parameter int OUT_W      = 8,
  parameter int SETTLE_N   = 4,
  parameter int SETTLE_MAX = 64,
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      dual_sweep,
  input  logic [OUT_W-1:0]          start_pat_a,
  input  logic [OUT_W-1:0]          start_pat_b,
  output logic                      done,
  output logic                      err_timeout,
  output logic [IN_W-1:0]           dev_in,
  output logic                      dev_clk,
  input  logic [OUT_W-1:0]          dev_out,
  output logic                      wr_valid,
  input  logic                      wr_ready,
  output logic [IN_W:0]             wr_addr,
  output logic [2*OUT_W+IN_W-1:0]   wr_data
);
  localparam int ADDR_W = IN_W + 1;
  localparam int MAXC   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int TMR_W  = $clog2(MAXC + 1);
  localparam logic [IN_W-1:0] LAST_VAL = {IN_W{1'b1}};

  seq_state_t        state;
  logic              tst;
  logic              sweep;
  logic              dual_q;
  logic              err_q;
  logic [IN_W-1:0]   value;
  logic [ADDR_W-1:0] addr;
  logic [OUT_W-1:0]  cap_q, pat_a_q, pat_b_q, target;
  logic              tmr_run, tmr_last, settled, timeout;
  logic [TMR_W-1:0]  tmr_len;
  logic              start_go, accept, last_rec, more_sweep, det_clr, cap_vld;

  assign target     = sweep ? pat_b_q : pat_a_q;
  assign start_go   = start && (state == S_IDLE || state == S_DONE);
  assign accept     = (state == S_WRITE) && wr_ready;
  assign last_rec   = (value == LAST_VAL);
  assign more_sweep = !sweep && dual_q;
  assign det_clr    = start_go || (accept && (!last_rec || more_sweep));
  assign tmr_run    = (state == S_DRIVE) || (state == S_HOLD);
  assign tmr_len    = (state == S_DRIVE) ? TMR_W'(SETUP_CYC) : TMR_W'(HOLD_CYC);
  assign cap_vld    = (state == S_HOLD) && tmr_last && !tst;

  pld_phase_timer #(.CNT_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .len(tmr_len), .last(tmr_last)
  );

  pld_settle_det #(.OUT_W(OUT_W), .SETTLE_N(SETTLE_N), .SETTLE_MAX(SETTLE_MAX)) u_settle (
    .clk(clk), .rst_n(rst_n), .clr(det_clr), .cap_vld(cap_vld),
    .cap_val(dev_out), .target(target), .settled(settled), .timeout(timeout)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      tst     <= 1'b0;
      sweep   <= 1'b0;
      dual_q  <= 1'b0;
      err_q   <= 1'b0;
      value   <= IN_W'(1);
      addr    <= '0;
      cap_q   <= '0;
      pat_a_q <= '0;
      pat_b_q <= '0;
    end else begin
      unique case (state)
        S_IDLE, S_DONE: if (start) begin
          pat_a_q <= start_pat_a;
          pat_b_q <= start_pat_b;
          dual_q  <= dual_sweep;
          sweep   <= 1'b0;
          value   <= IN_W'(1);
          addr    <= '0;
          tst     <= 1'b0;
          err_q   <= 1'b0;
          state   <= S_DRIVE;
        end
        S_DRIVE: if (tmr_last) state <= S_PULSE;
        S_PULSE: state <= S_HOLD;
        S_HOLD: if (tmr_last) begin
          cap_q <= dev_out;
          state <= S_EVAL;
        end
        S_EVAL: begin
          if (tst)          state <= S_WRITE;
          else if (settled) begin tst <= 1'b1; state <= S_DRIVE; end
          else if (timeout) begin err_q <= 1'b1; state <= S_DONE; end
          else              state <= S_DRIVE;
        end
        S_WRITE: if (wr_ready) begin
          addr <= addr + ADDR_W'(1);
          tst  <= 1'b0;
          if (!last_rec) begin
            value <= value + IN_W'(1);
            state <= S_DRIVE;
          end else if (more_sweep) begin
            sweep <= 1'b1;
            value <= IN_W'(1);
            state <= S_DRIVE;
          end else begin
            state <= S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done        = (state == S_DONE);
  assign err_timeout = err_q;
  assign dev_clk     = (state == S_PULSE);
  assign dev_in      = tst ? value : '0;
  assign wr_valid    = (state == S_WRITE);
  assign wr_addr     = addr;
  assign wr_data     = {target, value, cap_q};

  // R7: the strobe lasts one cycle
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    dev_clk |=> !dev_clk);
  // R7: inputs do not move into the strobe cycle
  a_r7_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
    dev_clk |-> $stable(dev_in));
  // R4: a test strobe never applies the all-zero value
  a_r4_test_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_clk && tst) |-> (dev_in != '0));
  // R8: a stalled record is held intact
  a_r8_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R5: each accepted record advances the address by one
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (wr_addr == $past(wr_addr) + ADDR_W'(1)));
  // R9: done holds until start
  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  // R3: a timeout is only reported with the run finished
  a_r3_err_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> done);
endmodule

// File: tb/tb_pld_sweep_seq.sv
`timescale 1ns/1ps
module tb_pld_sweep_seq;
  localparam int IN_W = 3, OUT_W = 4, SETTLE_N = 3, SETTLE_MAX = 12;
  localparam int SETUP_CYC = 2, HOLD_CYC = 1;
  localparam int REC_W = 2*OUT_W + IN_W;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dual = 1'b0, wr_ready = 1'b1;
  logic [OUT_W-1:0] pat_a = '0, pat_b = '0;
  logic done, err_timeout, dev_clk, wr_valid;
  logic [IN_W-1:0] dev_in;
  logic [OUT_W-1:0] dev_out;
  logic [IN_W:0] wr_addr;
  logic [REC_W-1:0] wr_data;

  always #10 clk = ~clk;

  pld_sweep_seq #(.IN_W(IN_W), .OUT_W(OUT_W), .SETTLE_N(SETTLE_N), .SETTLE_MAX(SETTLE_MAX),
    .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dual_sweep(dual),
    .start_pat_a(pat_a), .start_pat_b(pat_b), .done(done), .err_timeout(err_timeout),
    .dev_in(dev_in), .dev_clk(dev_clk), .dev_out(dev_out), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data));

  // Device model: zero input shifts in sbit (stable at 0000 or 1111), else adds the input
  logic [OUT_W-1:0] q;
  logic sbit = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (dev_clk) q <= (dev_in == '0) ? {q[OUT_W-2:0], sbit} : q + {1'b0, dev_in};
  end
  assign dev_out = q;

  // Sink throttle
  bit thr = 1'b0;
  logic [7:0] lf = 8'h5A;
  always @(posedge clk) begin
    #2;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    wr_ready = thr ? (lf[0] & lf[2]) : 1'b1;
  end

  // Monitor counters
  int m_checks = 0, m_fails = 0;
  int zstr = 0, tstr = 0, nrec = 0, first_z = -1, allstr = 0, stab = 0, hold_left = 0;
  logic [IN_W-1:0] prev_in = '0, str_in = '0, exp_val = 3'd1;
  logic [IN_W:0] exp_addr = '0, p_addr = '0;
  logic [REC_W-1:0] p_data = '0;
  bit msweep = 1'b0, pend = 1'b0;

  task automatic mchk(input bit ok, input string tag, input longint act, input longint exp);
    m_checks++;
    if (!ok) begin
      m_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (start) begin
        zstr = 0; tstr = 0; nrec = 0; first_z = -1; allstr = 0;
        exp_addr = '0; exp_val = 3'd1; msweep = 1'b0; sbit = 1'b0;
      end
      if (dev_in == prev_in) stab++; else stab = 0;
      prev_in = dev_in;
      if (hold_left > 0) begin
        mchk(dev_in == str_in, "R7 hold after strobe", dev_in, str_in);
        hold_left--;
      end
      if (pend) begin
        mchk(wr_valid && wr_addr == p_addr && wr_data == p_data, "R8 stalled record held",
             {wr_valid, wr_addr, wr_data}, {1'b1, p_addr, p_data});
        pend = 1'b0;
      end
      if (dev_clk) begin
        allstr++;
        mchk(stab >= SETUP_CYC, "R7 setup before strobe", stab, SETUP_CYC);
        str_in = dev_in;
        hold_left = HOLD_CYC;
        if (dev_in == '0) zstr++; else tstr++;
      end
      if (wr_valid && wr_ready) begin
        logic [OUT_W-1:0] tgt;
        tgt = msweep ? pat_b : pat_a;
        mchk(wr_addr == exp_addr, "R5 address", wr_addr, exp_addr);
        mchk(wr_data[OUT_W+IN_W-1:OUT_W] == exp_val, "R4 applied value",
             wr_data[OUT_W+IN_W-1:OUT_W], exp_val);
        mchk(wr_data[REC_W-1:OUT_W+IN_W] == tgt, "R6 record target",
             wr_data[REC_W-1:OUT_W+IN_W], tgt);
        mchk(wr_data[OUT_W-1:0] == tgt + OUT_W'(exp_val), "R5 captured output",
             wr_data[OUT_W-1:0], tgt + OUT_W'(exp_val));
        mchk(tstr == 1 && zstr >= SETTLE_N, "R1 strobes per record", {tstr, zstr}, {1, SETTLE_N});
        if (first_z < 0) first_z = zstr;
        zstr = 0; tstr = 0; nrec++;
        exp_addr = exp_addr + 1'b1;
        if (exp_val == 3'd7) begin
          if (dual && !msweep) begin msweep = 1'b1; exp_val = 3'd1; sbit = 1'b1; end
        end else exp_val = exp_val + 1'b1;
      end else if (wr_valid) begin
        pend = 1'b1; p_addr = wr_addr; p_data = wr_data;
      end
    end
  end

  // Main sequence
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_to_done(input logic [OUT_W-1:0] a, input logic [OUT_W-1:0] b, input bit d);
    int n;
    @(posedge clk); #2;
    pat_a = a; pat_b = b; dual = d; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done, "R9 run reaches done", done, 1);
  endtask

  task automatic t_reset_state;
    chk(!done && !err_timeout && !dev_clk && !wr_valid && dev_in == '0, "R10 reset state",
        {done, err_timeout, dev_clk, wr_valid, dev_in}, 0);
  endtask

  task automatic t_single_sweep;
    thr = 1'b0;
    run_to_done(4'h0, 4'h0, 1'b0);
    chk(nrec == 7, "R4 record count single sweep", nrec, 7);
    chk(first_z == SETTLE_N, "R2 settle clocks from settled device", first_z, SETTLE_N);
    chk(!err_timeout, "R3 no timeout on success", err_timeout, 0);
  endtask

  task automatic t_done_idle;
    int s0, r0;
    s0 = allstr; r0 = nrec;
    repeat (20) @(negedge clk);
    chk(done && allstr == s0 && nrec == r0, "R9 idle while done", {done, allstr, nrec}, {1'b1, s0, r0});
  endtask

  task automatic t_dual_backpressure;
    thr = 1'b1;
    run_to_done(4'h0, 4'hF, 1'b1);
    thr = 1'b0;
    chk(nrec == 14, "R6 record count dual sweep", nrec, 14);
    chk(exp_addr == 14, "R5 final address", exp_addr, 14);
  endtask

  task automatic t_timeout;
    run_to_done(4'h5, 4'h0, 1'b0);
    chk(err_timeout, "R3 timeout flag", err_timeout, 1);
    chk(nrec == 0, "R3 no records on timeout", nrec, 0);
    chk(allstr == SETTLE_MAX, "R3 strobes before timeout", allstr, SETTLE_MAX);
  endtask

  task automatic t_restart_clears;
    @(posedge clk); #2;
    pat_a = 4'h0; dual = 1'b0; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    @(negedge clk);
    chk(!err_timeout && !done, "R9 start clears error", {err_timeout, done}, 0);
    begin
      int n;
      n = 0;
      while (!done && n < 5000) begin @(negedge clk); n++; end
    end
    chk(done && !err_timeout && nrec == 7, "R9 restarted run completes",
        {done, err_timeout, nrec}, {1'b1, 1'b0, 7});
  endtask

  bit finished = 1'b0;
  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_single_sweep();
    t_done_idle();
    t_dual_backpressure();
    t_timeout();
    t_restart_clears();
    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks + m_checks, fails + m_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks + m_checks + 1, fails + m_fails + 1);
      $finish;
    end
  end
endmodule